// File: doc/BRIEF.md
# Comma-Based Symbol Boundary Aligner

This block sits behind a 10-bit deserializer whose word boundary can fall anywhere in the serial stream. It treats the previous and current received words as one continuous 20-bit bit sequence and looks for a configurable comma symbol at every one of the ten possible bit offsets. When it finds the comma, it locks that offset and barrel-shifts every later word so that symbol boundaries line up with word boundaries. The aligned words leave the block one beat later on a valid/ready stream.

Once locked, the block stops searching. It watches the aligned words for illegal code groups, using a counter that goes up on a bad word and down on a good one. Alignment is given up only when the count reaches a configurable limit, so a short burst of noise does not throw away a correct boundary. After alignment is lost, the search starts again.

Flow control works as follows. The input is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained that cycle. A word held on the output while `out_ready` is low stays unchanged until it is taken. The control inputs and status outputs are plain level signals.

Top module: `sym_boundary_aligner`

## Requirements
- R1: After reset `aligned` is 0, `out_valid` is 0, `offset` is 0 and `in_ready` is 1.
- R2: Bit 9 of each word is the earliest on the line. The search window is {previous accepted word, current word}, and offset o selects window bits [o+9:o]. When the block is not aligned and an accepted word makes a window candidate match the comma, the block locks to that offset, reports it on `offset` and presents the candidate itself on `out_data` with `out_valid` high one cycle later.
- R3: A candidate also matches when it equals the bitwise complement of `cfg_comma` on the cared-for bits.
- R4: Only bit positions where `cfg_mask` is 1 take part in the comparison. Positions where it is 0 are don't-care.
- R5: While aligned, every accepted word yields window bits [offset+9:offset] on `out_data` with `out_valid` high on the following cycle.
- R6: While aligned, `offset` does not change, and a comma appearing at another offset has no effect on `offset` or `aligned`.
- R7: An aligned word is a legal code group when its upper 6 bits have 2 to 4 ones, its lower 4 bits have 1 to 3 ones, and the whole word has 4 to 6 ones. An illegal word raises the error count by one. A legal word lowers it by one, saturating at 0. Alignment drops on the word that brings the count to `cfg_err_limit`.
- R8: The word that ends alignment is not presented (`out_valid` stays 0 after it). The search resumes with the next accepted word and can lock to a new offset.
- R9: When `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` and `out_valid` hold. When `out_ready` returns, a word waiting on the input is accepted on that same edge.
- R10: `out_valid` is never 1 while `aligned` is 0. Words received during the search are not presented.
- R11: When several offsets match at once, the lowest offset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received word available |
| in_ready | output | 1 | Block accepts the received word |
| in_data | input | 10 | Raw deserializer word, bit 9 earliest |
| cfg_comma | input | 10 | Comma symbol to search for |
| cfg_mask | input | 10 | 1 = bit position compared |
| cfg_err_limit | input | 4 | Net error count that ends alignment |
| out_valid | output | 1 | Aligned word available |
| out_ready | input | 1 | Consumer takes the aligned word |
| out_data | output | 10 | Aligned word |
| aligned | output | 1 | Boundary locked |
| offset | output | 4 | Locked bit offset (0 to 9) |

## Verification
Lock, `offset` and the first aligned word all become visible one cycle after the edge that accepts the word completing the comma. The bench therefore drives each word half a cycle before an edge and samples on the falling edge that follows it. With a nonzero skew the comma straddles two raw words, so it emerges one beat after it began. The expected stream is the transmitted symbol sequence delayed by that one beat, and the checks index into it accordingly. Loss of alignment, the held output under back-pressure and the frozen offset are each sampled after the very word that should (or should not) change them.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_st_e;

  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/sba_offset_search.sv
module sba_offset_search #(
  parameter int W     = 10,
  parameter int OFF_W = 4
) (
  input  logic [2*W-1:0]   window_i,
  input  logic [W-1:0]     comma_i,
  input  logic [W-1:0]     mask_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] hit_off_o
);

  logic [W-1:0] match;

  for (genvar o = 0; o < W; o++) begin : g_off
    logic [W-1:0] cand;
    assign cand     = window_i[o+W-1:o];
    assign match[o] = (((cand ^ comma_i) & mask_i) == '0) ||
                      (((cand ^ ~comma_i) & mask_i) == '0);
  end

  // lowest offset has priority (R11)
  always_comb begin
    hit_o     = |match;
    hit_off_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (match[k]) hit_off_o = OFF_W'(k);
    end
  end

endmodule

// File: rtl/sba_shifter.sv
module sba_shifter #(
  parameter int W     = 10,
  parameter int OFF_W = 4
) (
  input  logic [2*W-1:0]   window_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [W-1:0]     word_o
);

  logic [W-1:0] cands [W];

  for (genvar k = 0; k < W; k++) begin : g_tap
    assign cands[k] = window_i[k+W-1:k];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < W; k++) begin
      if (off_i == OFF_W'(k)) word_o = cands[k];
    end
  end

endmodule

// File: rtl/sba_code_screen.sv
module sba_code_screen #(
  parameter int W    = 10,
  parameter int HI_W = 6
) (
  input  logic [W-1:0] word_i,
  output logic         legal_o
);
  import sba_pkg::*;

  localparam int LO_W = W - HI_W;

  logic [HI_W-1:0] hi;
  logic [LO_W-1:0] lo;
  int unsigned     n_hi, n_lo, n_all;

  assign hi = word_i[W-1:LO_W];
  assign lo = word_i[LO_W-1:0];

  // each sub-block and the whole word must sit within one of balance
  always_comb begin
    n_hi    = ones32(32'(hi));
    n_lo    = ones32(32'(lo));
    n_all   = n_hi + n_lo;
    legal_o = (n_hi  + 1 >= HI_W / 2) && (n_hi  <= HI_W / 2 + 1) &&
              (n_lo  + 1 >= LO_W / 2) && (n_lo  <= LO_W / 2 + 1) &&
              (n_all + 1 >= W / 2)    && (n_all <= W / 2 + 1);
  end

endmodule

// File: rtl/sba_sync_fsm.sv
module sba_sync_fsm #(
  parameter int OFF_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] hit_off_i,
  input  logic             legal_i,
  input  logic [CNT_W-1:0] err_limit_i,
  output logic             aligned_o,
  output logic             lock_next_o,
  output logic [OFF_W-1:0] offset_o
);
  import sba_pkg::*;

  sync_st_e         st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] err_q, err_d;
  logic [CNT_W:0]   err_inc;

  always_comb begin
    st_d    = st_q;
    off_d   = off_q;
    err_d   = err_q;
    err_inc = {1'b0, err_q} + 1'b1;
    unique case (st_q)
      ST_HUNT: begin
        if (beat_i && hit_i) begin
          st_d  = ST_LOCK;
          off_d = hit_off_i;
          err_d = '0;
        end
      end
      ST_LOCK: begin
        if (beat_i) begin
          if (!legal_i) begin
            if (err_inc >= {1'b0, err_limit_i}) begin
              st_d  = ST_HUNT;
              err_d = '0;
            end else begin
              err_d = err_inc[CNT_W-1:0];
            end
          end else if (err_q != '0) begin
            err_d = err_q - 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      off_q <= '0;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      off_q <= off_d;
      err_q <= err_d;
    end
  end

  assign aligned_o   = (st_q == ST_LOCK);
  assign lock_next_o = (st_d == ST_LOCK);
  assign offset_o    = off_q;

  assert_offset_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && $past(st_q) == ST_LOCK) |-> off_q == $past(off_q));

  assert_lock_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && $past(st_q) == ST_HUNT) |-> $past(beat_i && hit_i));

  assert_err_clear_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT) |-> err_q == '0);

  assert_err_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && $past(st_q) == ST_LOCK) |->
      (err_q == $past(err_q)) || (err_q == $past(err_q) + 1'b1) ||
      (err_q == $past(err_q) - 1'b1));

endmodule

// File: rtl/sym_boundary_aligner.sv
module sym_boundary_aligner #(
  parameter int WORD_W = 10,
  parameter int HI_W   = 6,
  parameter int CNT_W  = 4,
  parameter int OFF_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] cfg_comma,
  input  logic [WORD_W-1:0] cfg_mask,
  input  logic [CNT_W-1:0]  cfg_err_limit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              aligned,
  output logic [OFF_W-1:0]  offset
);

  localparam int WIN_W = 2 * WORD_W;

  logic [WORD_W-1:0] prev_q;
  logic [WIN_W-1:0]  window;
  logic              beat, hit, legal, lock_next;
  logic [OFF_W-1:0]  hit_off, sel_off;
  logic [WORD_W-1:0] word;
  logic              out_valid_q;
  logic [WORD_W-1:0] out_data_q;

  assign in_ready = !out_valid_q || out_ready;
  assign beat     = in_valid && in_ready;
  assign window   = {prev_q, in_data};
  assign sel_off  = aligned ? offset : hit_off;

  sba_offset_search #(.W(WORD_W), .OFF_W(OFF_W)) u_search (
    .window_i (window),
    .comma_i  (cfg_comma),
    .mask_i   (cfg_mask),
    .hit_o    (hit),
    .hit_off_o(hit_off)
  );

  sba_shifter #(.W(WORD_W), .OFF_W(OFF_W)) u_shift (
    .window_i(window),
    .off_i   (sel_off),
    .word_o  (word)
  );

  sba_code_screen #(.W(WORD_W), .HI_W(HI_W)) u_screen (
    .word_i (word),
    .legal_o(legal)
  );

  sba_sync_fsm #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_i     (beat),
    .hit_i      (hit),
    .hit_off_i  (hit_off),
    .legal_i    (legal),
    .err_limit_i(cfg_err_limit),
    .aligned_o  (aligned),
    .lock_next_o(lock_next),
    .offset_o   (offset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (beat) begin
        prev_q      <= in_data;
        out_data_q  <= word;
        out_valid_q <= lock_next;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  assert_valid_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> aligned);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_loss_drops_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aligned) |-> !out_valid);

endmodule

// File: tb/sim_sym_boundary_aligner.sv
module sim_sym_boundary_aligner;

  localparam logic [9:0] K_COMMA = 10'b1100000101;
  localparam logic [9:0] D_A     = 10'b1010101010;
  localparam logic [9:0] D_B     = 10'b0101010101;
  localparam logic [9:0] D_C     = 10'b1001110001;
  localparam logic [9:0] BAD     = 10'b0000000000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready, aligned;
  logic [9:0] in_data, cfg_comma, cfg_mask, out_data;
  logic [3:0] cfg_err_limit, offset;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sym_boundary_aligner u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_comma(cfg_comma), .cfg_mask(cfg_mask),
    .cfg_err_limit(cfg_err_limit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .aligned(aligned), .offset(offset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    cfg_comma = K_COMMA; cfg_mask = 10'h3FF; cfg_err_limit = 4'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic beat(input logic [9:0] w);
    in_data = w; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [9:0] skewed(input logic [9:0] p, input logic [9:0] s, input int sk);
    logic [19:0] t;
    t = {p, s} >> sk;
    return t[9:0];
  endfunction

  // transmits symbols with a bit skew, checks lock timing and aligned data
  task automatic run_align(input int sk, input logic [9:0] comma_sym, input string tag);
    logic [9:0] syms [8];
    logic [9:0] prev;
    int lag;
    syms = '{D_A, D_B, D_A, comma_sym, D_C, D_B, D_A, D_C};
    prev = D_A;
    lag  = (sk != 0) ? 1 : 0;
    do_reset();
    for (int b = 0; b < 8; b++) begin
      beat(skewed(prev, syms[b], sk));
      prev = syms[b];
      if (b >= 3 + lag) begin
        chk({tag, " lock"}, aligned, 1);
        chk({tag, " offset"}, offset, (10 - sk) % 10);
        chk({tag, " R5 valid"}, out_valid, 1);
        chk({tag, " R5 data"}, out_data, syms[b - lag]);
      end else begin
        chk({tag, " R10 no valid before lock"}, out_valid, 0);
        chk({tag, " R10 not aligned"}, aligned, 0);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 aligned", aligned, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 offset", offset, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_mask();
    do_reset();
    cfg_mask = 10'b1111110000;
    beat(D_A);
    beat(D_A);
    chk("R4 no early lock", aligned, 0);
    beat(10'b1100001010);
    chk("R4 masked lock", aligned, 1);
    chk("R4 masked offset", offset, 0);
    chk("R4 masked data", out_data, 10'b1100001010);
  endtask

  task automatic t_priority();
    do_reset();
    cfg_mask = 10'b0;
    beat(D_B);
    chk("R11 lock", aligned, 1);
    chk("R11 lowest offset", offset, 0);
    chk("R11 data", out_data, D_B);
  endtask

  task automatic t_frozen();
    run_align(3, K_COMMA, "R6 setup");
    beat(K_COMMA);
    chk("R6 aligned kept", aligned, 1);
    chk("R6 offset kept", offset, 7);
    beat(D_A);
    beat(D_A);
    chk("R6 aligned kept later", aligned, 1);
    chk("R6 offset kept later", offset, 7);
  endtask

  task automatic t_hysteresis();
    logic [9:0] prev;
    logic [9:0] syms [4];
    run_align(0, K_COMMA, "R7 setup");
    cfg_err_limit = 4'd3;
    beat(BAD);
    chk("R7 err1 aligned", aligned, 1);
    chk("R7 err1 data", out_data, BAD);
    beat(BAD);
    chk("R7 err2 aligned", aligned, 1);
    beat(D_A);
    chk("R7 good aligned", aligned, 1);
    beat(BAD);
    chk("R7 err2 again aligned", aligned, 1);
    beat(BAD);
    chk("R7 limit reached", aligned, 0);
    chk("R8 valid dropped", out_valid, 0);
    syms = '{D_A, D_B, K_COMMA, D_C};
    prev = D_A;
    for (int b = 0; b < 4; b++) begin
      beat(skewed(prev, syms[b], 5));
      prev = syms[b];
      if (b < 3) chk("R8 still searching", aligned, 0);
    end
    chk("R8 relock", aligned, 1);
    chk("R8 new offset", offset, 5);
    chk("R8 comma out", out_data, K_COMMA);
  endtask

  task automatic t_backpressure();
    run_align(0, K_COMMA, "R9 setup");
    out_ready = 1'b0;
    #1;
    chk("R9 in_ready low", in_ready, 0);
    in_data = D_B; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 held valid", out_valid, 1);
    chk("R9 held data", out_data, D_C);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 accepted on release", out_data, D_B);
    chk("R9 valid after release", out_valid, 1);
    beat(D_A);
    chk("R9 next word", out_data, D_A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_align(0, K_COMMA, "R2 skew0");
    run_align(3, K_COMMA, "R2 skew3");
    run_align(9, K_COMMA, "R2 skew9");
    run_align(7, ~K_COMMA, "R3 complement skew7");
    t_mask();
    t_priority();
    t_frozen();
    t_hysteresis();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule